// File: doc/BRIEF.md
# Bus Handshake Rule Monitor

This block sits beside a parallel bus agent and watches its handshake pins: cycle frame, initiator ready, target ready, device select and stop, plus a flag that says whether the watched agent is currently the initiator. On every clock it checks a small set of implication rules. Each rule has a trigger, which is taken from the sample one cycle earlier (or from the same cycle for the select rule), and a demand on the present sample. A rule whose trigger is false makes no demand in that cycle.

For every rule the monitor keeps two sticky bits. One is an error bit that sets on the first cycle where the demand fails while the trigger is true. The other is a coverage bit that sets on the first cycle where the trigger is true. The coverage bits are also summed into a count of exercised rules. Both sets of bits stay set until synchronous reset. The monitor is meant to stay in the netlist during simulation and emulation, and regression scripts read its error and coverage outputs.

Top module: `bus_rule_monitor`

## Requirements
- R1: The bus pins are active low and the initiator flag is active high. After synchronous reset `ruleErr`, `ruleHit` and `hitCount` read zero and `anyErr` is low.
- R2: Rule bit 0 (select): a cycle with target ready asserted and device select deasserted sets `ruleErr[0]`. A cycle with target ready asserted sets `ruleHit[0]`.
- R3: Rule bit 1 (stop hold): if the previous cycle had target ready and stop both asserted, the present cycle must have stop asserted, or `ruleErr[1]` sets. The triggered cycle sets `ruleHit[1]`.
- R4: Rule bit 2 (initiator wait): a wait counter counts earlier consecutive cycles with frame asserted and initiator ready low. If the previous cycle had the initiator flag high, frame asserted, initiator ready low and a count of 7, the present cycle must have initiator ready asserted, or `ruleErr[2]` sets. The triggered cycle sets `ruleHit[2]`.
- R5: Rule bit 3 (target-ready hold): if the previous cycle had target ready asserted and its data phase did not end, the present cycle must keep target ready asserted, or `ruleErr[3]` sets. A data phase ends in a cycle with both readies asserted, or with stop asserted. The triggered cycle sets `ruleHit[3]`.
- R6: A rule whose trigger is false makes no demand. For example, stop dropping without a prior target-ready-and-stop cycle, or a long wait while the agent is not the initiator, changes neither its error bit nor its coverage bit.
- R7: Error bits are sticky until synchronous reset, and `anyErr` is the OR of all error bits.
- R8: Coverage bits are sticky until synchronous reset, and `hitCount` equals the number of set coverage bits.
- R9: An error or coverage bit caused by the pins sampled at rising edge k is visible right after rising edge k+1, and not earlier.
- R10: The wait counter clears on any cycle where frame is deasserted or initiator ready is asserted, and it saturates at 7. A late initiator ready therefore still triggers the rule, and an initiator ready seen earlier restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frameN | input | 1 | Cycle frame, active low |
| irdyN | input | 1 | Initiator ready, active low |
| trdyN | input | 1 | Target ready, active low |
| devselN | input | 1 | Device select, active low |
| stopN | input | 1 | Stop request, active low |
| isMaster | input | 1 | Watched agent is the initiator, active high |
| ruleErr | output | 4 | Sticky per-rule violation bits (0 select, 1 stop hold, 2 initiator wait, 3 target-ready hold) |
| anyErr | output | 1 | OR of all violation bits |
| ruleHit | output | 4 | Sticky per-rule trigger coverage bits, same bit order |
| hitCount | output | 3 | Number of rules whose trigger has fired |

## Verification
Every result of this monitor is due exactly two rising edges after the pins that cause it are sampled. One edge loads the input sample register, and the next loads the sticky ledger. For the rules with a previous-cycle trigger, the clock is the cycle that carries the demand, not the cycle that carries the trigger. The bench drives one pin vector per cycle on the falling edge. With each vector it queues the full expected output state, tagged with a due cycle two edges later. A monitor process compares the outputs on the falling edge of exactly that cycle, so a result that arrives early or late fails the item next to it. The wait-counter scenarios count cycles one by one around the seventh waiting cycle, including a restart after an early initiator ready.

// File: rtl/bus_rule_pkg.sv
package bus_rule_pkg;

  localparam int RULE_COUNT = 4;
  localparam int HIT_W      = $clog2(RULE_COUNT + 1);

  // rule bit positions, shared by the ledger outputs
  localparam int RULE_SEL       = 0;
  localparam int RULE_STOP_HOLD = 1;
  localparam int RULE_IRDY_WAIT = 2;
  localparam int RULE_TRDY_HOLD = 3;

  // one active-high snapshot of the handshake pins
  typedef struct packed {
    logic frame;
    logic irdy;
    logic trdy;
    logic devsel;
    logic stop;
    logic master;
  } busSampleT;

  // strobes from the rule evaluator to the ledger
  typedef struct packed {
    logic [RULE_COUNT-1:0] fire;
    logic [RULE_COUNT-1:0] viol;
  } ruleStrobesT;

endpackage

// File: rtl/bus_rule_front.sv
module bus_rule_front
  import bus_rule_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic             trdyN,
  input  logic             devselN,
  input  logic             stopN,
  input  logic             isMaster,
  output busSampleT        curS,
  output logic [CNT_W-1:0] waitCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  busSampleT        sampleQ;
  logic [CNT_W-1:0] cntQ;
  logic             waiting;

  // pins become active high at the register input
  always_ff @(posedge clk) begin
    if (rst) begin
      sampleQ <= '0;
    end else begin
      sampleQ.frame  <= ~frameN;
      sampleQ.irdy   <= ~irdyN;
      sampleQ.trdy   <= ~trdyN;
      sampleQ.devsel <= ~devselN;
      sampleQ.stop   <= ~stopN;
      sampleQ.master <= isMaster;
    end
  end

  // cntQ holds how many earlier consecutive samples waited on irdy
  assign waiting = sampleQ.frame && !sampleQ.irdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
    end else if (!waiting) begin
      cntQ <= '0;
    end else if (cntQ != CNT_MAX) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign curS    = sampleQ;
  assign waitCnt = cntQ;

  a_r10_cnt_clear: assert property (@(posedge clk) disable iff (rst)
    (!curS.frame || curS.irdy) |=> (waitCnt == '0));

  a_r10_cnt_saturate: assert property (@(posedge clk) disable iff (rst)
    (waitCnt == CNT_MAX && curS.frame && !curS.irdy) |=> (waitCnt == CNT_MAX));

endmodule

// File: rtl/bus_rule_eval.sv
module bus_rule_eval
  import bus_rule_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  busSampleT        curS,
  input  logic [CNT_W-1:0] waitCnt,
  output ruleStrobesT      strobes
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // triggers that come from the previous sample, held one cycle
  logic [RULE_COUNT-1:1] armNext;
  logic [RULE_COUNT-1:1] armQ;
  logic [RULE_COUNT-1:0] demand;
  logic                  phaseOpen;

  assign phaseOpen = curS.trdy && !curS.irdy && !curS.stop;

  always_comb begin
    armNext                 = '0;
    armNext[RULE_STOP_HOLD] = curS.trdy && curS.stop;
    armNext[RULE_IRDY_WAIT] = curS.master && curS.frame && !curS.irdy
                              && (waitCnt == CNT_MAX);
    armNext[RULE_TRDY_HOLD] = phaseOpen;
  end

  always_ff @(posedge clk) begin
    if (rst) armQ <= '0;
    else     armQ <= armNext;
  end

  // demand placed on the present sample by each rule
  always_comb begin
    demand                 = '0;
    demand[RULE_SEL]       = curS.devsel;
    demand[RULE_STOP_HOLD] = curS.stop;
    demand[RULE_IRDY_WAIT] = curS.irdy;
    demand[RULE_TRDY_HOLD] = curS.trdy;
  end

  always_comb begin
    strobes.fire           = '0;
    strobes.fire[RULE_SEL] = curS.trdy;
    for (int r = 1; r < RULE_COUNT; r++) begin
      strobes.fire[r] = armQ[r];
    end
    strobes.viol = strobes.fire & ~demand;
  end

  a_r3_stop_hold_armed: assert property (@(posedge clk) disable iff (rst)
    (curS.trdy && curS.stop) |=> strobes.fire[RULE_STOP_HOLD]);

  a_r5_trdy_hold_armed: assert property (@(posedge clk) disable iff (rst)
    (curS.trdy && !curS.irdy && !curS.stop) |=> strobes.fire[RULE_TRDY_HOLD]);

  a_r4_wait_armed_only_as_master: assert property (@(posedge clk) disable iff (rst)
    !curS.master |=> !strobes.fire[RULE_IRDY_WAIT]);

endmodule

// File: rtl/bus_rule_ledger.sv
module bus_rule_ledger
  import bus_rule_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  ruleStrobesT           strobes,
  output logic [RULE_COUNT-1:0] errBits,
  output logic [RULE_COUNT-1:0] hitBits,
  output logic                  errAny,
  output logic [HIT_W-1:0]      hitTotal
);

  logic [RULE_COUNT-1:0] errQ;
  logic [RULE_COUNT-1:0] hitQ;

  for (genvar g = 0; g < RULE_COUNT; g++) begin : gRule
    always_ff @(posedge clk) begin
      if (rst) begin
        errQ[g] <= 1'b0;
        hitQ[g] <= 1'b0;
      end else begin
        if (strobes.viol[g]) errQ[g] <= 1'b1;
        if (strobes.fire[g]) hitQ[g] <= 1'b1;
      end
    end

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
      errQ[g] |=> errQ[g]);

    a_r7_viol_latches: assert property (@(posedge clk) disable iff (rst)
      strobes.viol[g] |=> errQ[g]);

    a_r8_hit_latches: assert property (@(posedge clk) disable iff (rst)
      strobes.fire[g] |=> hitQ[g]);

    a_r6_viol_needs_fire: assert property (@(posedge clk) disable iff (rst)
      strobes.viol[g] |-> strobes.fire[g]);
  end

  always_comb begin
    hitTotal = '0;
    for (int r = 0; r < RULE_COUNT; r++) begin
      hitTotal = hitTotal + HIT_W'(hitQ[r]);
    end
  end

  assign errBits = errQ;
  assign hitBits = hitQ;
  assign errAny  = |errQ;

endmodule

// File: rtl/bus_rule_monitor.sv
module bus_rule_monitor
  import bus_rule_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frameN,
  input  logic                  irdyN,
  input  logic                  trdyN,
  input  logic                  devselN,
  input  logic                  stopN,
  input  logic                  isMaster,
  output logic [RULE_COUNT-1:0] ruleErr,
  output logic                  anyErr,
  output logic [RULE_COUNT-1:0] ruleHit,
  output logic [HIT_W-1:0]      hitCount
);

  busSampleT        curS;
  logic [CNT_W-1:0] waitCnt;
  ruleStrobesT      strobes;

  bus_rule_front #(.CNT_W(CNT_W)) uFront (
    .clk     (clk),
    .rst     (rst),
    .frameN  (frameN),
    .irdyN   (irdyN),
    .trdyN   (trdyN),
    .devselN (devselN),
    .stopN   (stopN),
    .isMaster(isMaster),
    .curS    (curS),
    .waitCnt (waitCnt)
  );

  bus_rule_eval #(.CNT_W(CNT_W)) uEval (
    .clk    (clk),
    .rst    (rst),
    .curS   (curS),
    .waitCnt(waitCnt),
    .strobes(strobes)
  );

  bus_rule_ledger uLedger (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .errBits (ruleErr),
    .hitBits (ruleHit),
    .errAny  (anyErr),
    .hitTotal(hitCount)
  );

endmodule

// File: tb/bus_rule_monitor_test.sv
module bus_rule_monitor_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frameN = 1'b1, irdyN = 1'b1, trdyN = 1'b1;
  logic       devselN = 1'b1, stopN = 1'b1, isMaster = 1'b0;
  logic [3:0] ruleErr, ruleHit;
  logic       anyErr;
  logic [2:0] hitCount;

  int cyc = 0;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [3:0] expErr = '0;
  logic [3:0] expHit = '0;

  typedef struct {
    int         due;
    logic [3:0] err;
    logic [3:0] hit;
    string      tag;
  } expItemT;

  expItemT q[$];

  bus_rule_monitor uut (
    .clk(clk), .rst(rst), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .devselN(devselN), .stopN(stopN), .isMaster(isMaster),
    .ruleErr(ruleErr), .anyErr(anyErr), .ruleHit(ruleHit), .hitCount(hitCount)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare the item due this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      expItemT e;
      e = q.pop_front();
      vectors++;
      if (ruleErr !== e.err || anyErr !== (|e.err) || ruleHit !== e.hit ||
          hitCount !== 3'($countones(e.hit))) begin
        fails++;
        $display("FAIL %s: err=%b any=%b hit=%b cnt=%0d, expected err=%b any=%b hit=%b cnt=%0d",
                 e.tag, ruleErr, anyErr, ruleHit, hitCount,
                 e.err, |e.err, e.hit, $countones(e.hit));
      end
    end
  end

  // driver: one active-high pin vector per cycle, with its expected outcome
  task automatic step(input bit f, input bit i, input bit t, input bit d,
                      input bit s, input bit m, input logic [3:0] addErr,
                      input logic [3:0] addHit, input string tag);
    @(negedge clk);
    frameN = ~f; irdyN = ~i; trdyN = ~t; devselN = ~d; stopN = ~s; isMaster = m;
    expErr = expErr | addErr;
    expHit = expHit | addHit;
    q.push_back('{cyc + 2, expErr, expHit, tag});
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 4'b0000, 4'b0000, tag);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic doReset();
    drain();
    @(negedge clk);
    rst = 1'b1;
    frameN = 1'b1; irdyN = 1'b1; trdyN = 1'b1; devselN = 1'b1; stopN = 1'b1; isMaster = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    expErr = '0;
    expHit = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R1 reset state");
    idle("R1 reset state held");

    // R2 pass, then R5 hold satisfied by a completed phase
    step(1, 0, 1, 1, 0, 0, 4'b0000, 4'b0001, "R2 trdy with devsel");
    step(1, 1, 1, 1, 0, 0, 4'b0000, 4'b1001, "R5 trdy held to completion");
    idle("R5 no demand after completed phase");

    // R6: stop drops without a prior trdy-and-stop cycle
    step(0, 0, 0, 0, 1, 0, 4'b0000, 4'b0000, "R6 lone stop");
    step(0, 0, 0, 0, 0, 0, 4'b0000, 4'b0000, "R6 stop drop untriggered");

    // R3 pass
    step(1, 0, 1, 1, 1, 0, 4'b0000, 4'b0001, "R3 trdy and stop");
    step(0, 0, 0, 1, 1, 0, 4'b0000, 4'b0010, "R3 stop held");
    idle("R3 quiet");

    // R3 violation
    step(1, 0, 1, 1, 1, 0, 4'b0000, 4'b0000, "R3 trdy and stop again");
    step(0, 0, 0, 0, 0, 0, 4'b0010, 4'b0000, "R3 stop dropped");
    idle("R7 stop error sticky");

    // R2 violation
    step(1, 1, 1, 0, 0, 0, 4'b0001, 4'b0000, "R2 trdy without devsel");
    idle("R7 any error held");

    // R5 violation
    step(1, 0, 1, 1, 0, 0, 4'b0000, 4'b0000, "R5 open phase");
    step(0, 0, 0, 0, 0, 0, 4'b1000, 4'b1000, "R5 trdy withdrawn early");
    idle("R7 errors sticky");
    idle("R8 coverage sticky");

    // R7/R8 clear on reset
    doReset();
    idle("R7 cleared by reset");

    // R6: long wait while not initiator
    for (int k = 0; k < 10; k++) step(1, 0, 0, 0, 0, 0, 4'b0000, 4'b0000, "R6 wait as target");
    idle("R6 no initiator-wait trigger");

    // R10: irdy restarts the window
    for (int k = 0; k < 5; k++) step(1, 0, 0, 0, 0, 1, 4'b0000, 4'b0000, "R10 first wait");
    step(1, 1, 0, 0, 0, 1, 4'b0000, 4'b0000, "R10 irdy clears counter");
    for (int k = 0; k < 7; k++) step(1, 0, 0, 0, 0, 1, 4'b0000, 4'b0000, "R10 second wait");
    step(1, 1, 0, 0, 0, 1, 4'b0000, 4'b0000, "R10 irdy in time");
    idle("R10 quiet");

    // R4 pass: irdy on the ninth cycle after eight waits
    for (int k = 0; k < 8; k++) step(1, 0, 0, 0, 0, 1, 4'b0000, 4'b0000, "R4 waiting");
    step(1, 1, 0, 0, 0, 1, 4'b0000, 4'b0100, "R4 irdy at limit");
    idle("R4 quiet");

    // R4 violation, R10 saturation keeps the trigger armed
    for (int k = 0; k < 8; k++) step(1, 0, 0, 0, 0, 1, 4'b0000, 4'b0000, "R4 waiting again");
    step(1, 0, 0, 0, 0, 1, 4'b0100, 4'b0000, "R4 irdy missed");
    step(0, 0, 0, 0, 0, 1, 4'b0000, 4'b0000, "R10 saturated trigger");
    idle("R9 final state");

    drain();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule